// File: doc/BRIEF.md
# Multi-channel compare-match timer

A bus-mapped timer block with a parameterised number of independent channels. Each channel owns an up-counter, a compare register and a control/status register. One shared run register at offset 0 holds a run bit for every channel. A running channel counts a slow reference tick, either directly or divided by 8, 32 or 128. When the counter meets its compare value, the channel raises a match flag. In periodic mode it then restarts from zero. In free-running mode it keeps counting and can wrap past all ones.

Software sets up a channel in a fixed order. It writes the control and compare registers, loads the counter, and then sets the channel's run bit. A new counter value only lands on the second reference tick after the write. Until then, software reads back the old value. The flags in the control register are cleared by writing that register with the flag bit at zero. Each channel drives its own interrupt line, which is high while the match flag is set and the channel's request type selects an interrupt.

Top module: `match_timer`

## Requirements
- R1: After reset, the run register, every control register and every counter read 0, every compare register reads all ones, and all interrupt lines are low.
- R2: The run register is at byte 0x00. Channel n's block starts at 0x10 + 0x10*n, with control at +0x0, counter at +0x4 and compare at +0x8. Run bits at or above NUM_CH read 0, and unmapped addresses read 0.
- R3: Setting run bit n makes channel n count. Clearing it holds the counter and leaves the control and compare registers unchanged.
- R4: Control bits 2:0 select the count source. 111 counts every reference tick, 100 counts every 8th, 101 every 32nd and 110 every 128th. Codes 0xx do not count. The divider restarts from zero while the channel is stopped, and the counter changes only in cycles with a reference tick.
- R5: Periodic mode is control bit 8 = 1. On a count where the counter equals the compare value, the counter becomes 0 and the match flag (bit 15) sets, so a period is compare+1 counts.
- R6: Free-running mode is bit 8 = 0. An equal count sets the match flag, but the counter still increments.
- R7: The overflow flag (bit 14) sets when a count takes the counter from all ones to zero without a compare match.
- R8: A control write with bit 15 or bit 14 at 0 clears that flag. Writing 1 to either bit leaves it as it was. If a flag is set in the same cycle as the write, the set wins.
- R9: irq_o[n] is high while channel n's match flag is set and bits 5:4 equal 2'b10. The other request codes keep irq_o[n] low.
- R10: A counter write takes effect at the second reference tick after it. Until then, reads return the old value, and counting continues on the old value.
- R11: Control bits 8, 7, 5:4 and 2:0 read back as written. The other non-flag bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
The bench goes after the exact match tick. If the counter were compared after incrementing, the flag would arrive one count early and the period would be compare instead of compare+1. It also checks the last count before each prescaler ratio fires, which catches an off-by-one divider or a divider that is not cleared while stopped. The delayed counter load is sampled after one tick and after two, so a design that loads at once or one tick late reads back wrong. Flag handling covers write-one-keeps, write-zero-clears and a wrap from all ones in free-running mode. Missing that wrap would leave the overflow flag clear.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int unsigned MATCH_B = 15;
  localparam int unsigned OVF_B   = 14;
  localparam int unsigned PER_B   = 8;
  localparam logic [31:0] CTRL_RW_MASK = 32'h0000_01B7;
  localparam logic [1:0]  REQ_IRQ = 2'b10;

  typedef enum logic [2:0] {
    CKS_DIV8   = 3'b100,
    CKS_DIV32  = 3'b101,
    CKS_DIV128 = 3'b110,
    CKS_DIV1   = 3'b111
  } cks_e;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale
  import mtmr_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       cnt_en_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         div_q <= '0;
    else if (!run_i)     div_q <= '0;
    else if (ref_tick_i) div_q <= div_q + 1'b1;
  end

  logic fire;
  always_comb begin
    unique case (sel_i)
      CKS_DIV1:   fire = 1'b1;
      CKS_DIV8:   fire = &div_q[2:0];
      CKS_DIV32:  fire = &div_q[4:0];
      CKS_DIV128: fire = &div_q[6:0];
      default:    fire = 1'b0;
    endcase
  end

  assign cnt_en_o = run_i && ref_tick_i && fire;
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
  import mtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             run_i,
  input  logic             ctrl_we_i,
  input  logic             cnt_we_i,
  input  logic             cmp_we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  logic [31:0]      cfg_q;
  logic             match_q, ovf_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, pend_q;
  logic [1:0]       pend_n_q;
  logic             cnt_en;

  mtmr_prescale #(.DIV_W(7)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .run_i      (run_i),
    .sel_i      (cfg_q[2:0]),
    .cnt_en_o   (cnt_en)
  );

  // pending counter load lands on the second reference tick
  logic load_now, step, hit, at_max;
  assign load_now = ref_tick_i && (pend_n_q == 2'd1);
  assign step     = cnt_en && !load_now;
  assign hit      = (cnt_q == cmp_q);
  assign at_max   = &cnt_q;

  logic match_keep, ovf_keep;
  assign match_keep = ctrl_we_i ? (match_q & wdata_i[MATCH_B]) : match_q;
  assign ovf_keep   = ctrl_we_i ? (ovf_q & wdata_i[OVF_B]) : ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      match_q  <= 1'b0;
      ovf_q    <= 1'b0;
      cnt_q    <= '0;
      cmp_q    <= '1;
      pend_q   <= '0;
      pend_n_q <= '0;
    end else begin
      if (ctrl_we_i) cfg_q <= wdata_i & CTRL_RW_MASK;
      if (cmp_we_i)  cmp_q <= wdata_i[CNT_W-1:0];
      match_q <= match_keep | (step && hit);
      ovf_q   <= ovf_keep | (step && at_max && !hit);
      if (cnt_we_i) begin
        pend_q   <= wdata_i[CNT_W-1:0];
        pend_n_q <= 2'd2;
      end else if (ref_tick_i && pend_n_q != 2'd0) begin
        pend_n_q <= pend_n_q - 2'd1;
      end
      if (load_now)                  cnt_q <= pend_q;
      else if (step && hit && cfg_q[PER_B]) cnt_q <= '0;
      else if (step)                 cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    ctrl_o          = cfg_q;
    ctrl_o[MATCH_B] = match_q;
    ctrl_o[OVF_B]   = ovf_q;
  end
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = match_q && (cfg_q[5:4] == REQ_IRQ);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned PAGE_W = ADDR_W - 4;

  logic [PAGE_W-1:0] page;
  logic [1:0]        word;
  logic              aligned;
  assign page    = bus_addr_i[ADDR_W-1:4];
  assign word    = bus_addr_i[3:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);

  logic [NUM_CH-1:0]            run_q;
  logic [NUM_CH-1:0]            ctrl_we_v;
  logic [NUM_CH-1:0][31:0]      ctrl_v;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, cmp_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (bus_we_i && aligned && page == '0 && word == 2'd0)
      run_q <= bus_wdata_i[NUM_CH-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic sel;
    assign sel = bus_we_i && aligned && (page == PAGE_W'(ch + 1));
    assign ctrl_we_v[ch] = sel && (word == 2'd0);

    mtmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_tick_i (ref_tick_i),
      .run_i      (run_q[ch]),
      .ctrl_we_i  (ctrl_we_v[ch]),
      .cnt_we_i   (sel && (word == 2'd1)),
      .cmp_we_i   (sel && (word == 2'd2)),
      .wdata_i    (bus_wdata_i),
      .ctrl_o     (ctrl_v[ch]),
      .cnt_o      (cnt_v[ch]),
      .cmp_o      (cmp_v[ch]),
      .irq_o      (irq_o[ch])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (aligned) begin
      if (page == '0 && word == 2'd0) bus_rdata_o[NUM_CH-1:0] = run_q;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (page == PAGE_W'(ch + 1)) begin
          case (word)
            2'd0: bus_rdata_o = ctrl_v[ch];
            2'd1: bus_rdata_o[CNT_W-1:0] = cnt_v[ch];
            2'd2: bus_rdata_o[CNT_W-1:0] = cmp_v[ch];
            default: bus_rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         ref_tick_i,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0]            ctrl_we_v,
  input logic [NUM_CH-1:0][31:0]      ctrl_v,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CH-1:0]            irq_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R4: counter moves only on reference ticks
    a_r4_count_on_ref_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_tick_i |=> $stable(cnt_v[n]));
    // R5: periodic match leaves counter at zero
    a_r5_periodic_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ctrl_v[n][15]) && $past(ctrl_v[n][8]) && ctrl_v[n][8]) |-> cnt_v[n] == '0);
    // R7: overflow appears together with a wrap to zero
    a_r7_overflow_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctrl_v[n][14]) |-> cnt_v[n] == '0);
    // R8: match flag only drops after a control write
    a_r8_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ctrl_v[n][15]) |-> $past(ctrl_we_v[n]));
    // R9: interrupt only with the match flag set
    a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> ctrl_v[n][15]);
    // R3: stopped channel without a tick keeps the counter
    a_r3_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[n] && !ref_tick_i) |=> $stable(cnt_v[n]));
  end
endmodule

bind match_timer mtmr_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_tick_i (ref_tick_i),
  .run_q      (run_q),
  .ctrl_we_v  (ctrl_we_v),
  .ctrl_v     (ctrl_v),
  .cnt_v      (cnt_v),
  .irq_o      (irq_o)
);

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;
  localparam int NUM_CH = 2;
  logic        clk_i = 0, rst_ni = 0, ref_tick_i = 0, bus_we_i = 0;
  logic [7:0]  bus_addr_i = 0;
  logic [31:0] bus_wdata_i = 0, bus_rdata_o;
  logic [NUM_CH-1:0] irq_o;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  match_timer #(.NUM_CH(NUM_CH), .CNT_W(32), .ADDR_W(8)) u_match_timer (.*);

  function automatic logic [7:0] a_ctrl(int n); return 8'(16 + 16*n);     endfunction
  function automatic logic [7:0] a_cnt(int n);  return 8'(16 + 16*n + 4); endfunction
  function automatic logic [7:0] a_cmp(int n);  return 8'(16 + 16*n + 8); endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1;
    @(negedge clk_i); bus_we_i = 0;
  endtask
  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask
  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr_i = a; #1; chk(req, bus_rdata_o, exp);
  endtask
  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk_i); ref_tick_i = 1;
      @(negedge clk_i); ref_tick_i = 0;
    end
  endtask
  task automatic load_cnt(input int ch, input logic [31:0] v);
    wr(a_cnt(ch), v); ticks(2);
  endtask

  task automatic t_reset;
    rdchk("R1 run", 8'h00, 0);
    for (int n = 0; n < NUM_CH; n++) begin
      rdchk("R1 ctrl", a_ctrl(n), 0);
      rdchk("R1 cnt", a_cnt(n), 0);
      rdchk("R1 cmp", a_cmp(n), 32'hFFFF_FFFF);
    end
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_map;
    wr(a_cmp(1), 32'h55);
    rdchk("R2 ch1 cmp", a_cmp(1), 32'h55);
    rdchk("R2 ch0 cmp untouched", a_cmp(0), 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rdchk("R2 run upper bits", 8'h00, 32'h3);
    wr(8'h00, 0);
    rdchk("R2 unmapped", 8'h04, 0);
    wr(a_ctrl(1), 32'hFFFF_FFFF);
    rdchk("R11 ctrl rw mask", a_ctrl(1), 32'h0000_01B7);
    wr(a_ctrl(1), 0);
  endtask

  task automatic t_periodic;
    wr(a_ctrl(0), 32'h127); wr(a_cmp(0), 4); load_cnt(0, 0);
    ticks(3);
    rdchk("R3 stopped no count", a_cnt(0), 0);
    wr(8'h00, 1);
    ticks(4);
    rdchk("R5 cnt at cmp", a_cnt(0), 4);
    rdchk("R5 no flag yet", a_ctrl(0), 32'h127);
    ticks(1);
    rdchk("R5 wrap to zero", a_cnt(0), 0);
    rdchk("R5 flag set", a_ctrl(0), 32'h8127);
    chk("R9 irq on", 32'(irq_o), 1);
    ticks(5);
    rdchk("R5 second period", a_cnt(0), 0);
    rdchk("R3 ch1 idle", a_cnt(1), 0);
  endtask

  task automatic t_clear;
    wr(a_ctrl(0), 32'hC127);
    rdchk("R8 write one keeps", a_ctrl(0), 32'h8127);
    wr(a_ctrl(0), 32'h0127);
    rdchk("R8 write zero clears", a_ctrl(0), 32'h0127);
    chk("R9 irq off", 32'(irq_o), 0);
    wr(a_ctrl(0), 32'h8107);
    rdchk("R8 one does not set", a_ctrl(0), 32'h0107);
    load_cnt(0, 0);
    ticks(5);
    rdchk("R9 flag with req none", a_ctrl(0), 32'h8107);
    chk("R9 no irq for req none", 32'(irq_o), 0);
  endtask

  task automatic t_stop;
    load_cnt(0, 0);
    ticks(2);
    wr(8'h00, 0);
    ticks(3);
    rdchk("R3 held count", a_cnt(0), 2);
    rdchk("R3 ctrl kept", a_ctrl(0), 32'h8107);
    rdchk("R3 cmp kept", a_cmp(0), 4);
  endtask

  task automatic t_prescale_one(input logic [31:0] ctrl, input int ratio, input string req);
    wr(8'h00, 0); wr(a_ctrl(0), ctrl); load_cnt(0, 0);
    wr(8'h00, 1);
    ticks(ratio - 1);
    rdchk(req, a_cnt(0), 0);
    ticks(1);
    rdchk(req, a_cnt(0), 1);
  endtask

  task automatic t_prescale;
    wr(a_cmp(0), 32'hFFFF);
    t_prescale_one(32'h104, 8,   "R4 div8");
    t_prescale_one(32'h105, 32,  "R4 div32");
    t_prescale_one(32'h106, 128, "R4 div128");
    t_prescale_one(32'h107, 1,   "R4 div1");
    wr(8'h00, 0); wr(a_ctrl(0), 32'h103); load_cnt(0, 0);
    wr(8'h00, 1); ticks(10);
    rdchk("R4 code 0xx stalls", a_cnt(0), 0);
    wr(8'h00, 0);
  endtask

  task automatic t_load;
    load_cnt(0, 0);
    wr(a_cnt(0), 10);
    rdchk("R10 old before tick", a_cnt(0), 0);
    ticks(1);
    rdchk("R10 old after one tick", a_cnt(0), 0);
    ticks(1);
    rdchk("R10 new after two", a_cnt(0), 10);
    wr(a_ctrl(0), 32'h107); wr(8'h00, 1);
    wr(a_cnt(0), 100);
    ticks(1);
    rdchk("R10 counts old value", a_cnt(0), 11);
    ticks(1);
    rdchk("R10 load over count", a_cnt(0), 100);
    wr(8'h00, 0);
  endtask

  task automatic t_overflow;
    wr(a_ctrl(1), 32'h027); wr(a_cmp(1), 5);
    load_cnt(1, 32'hFFFF_FFFE);
    wr(8'h00, 2);
    ticks(1);
    rdchk("R7 at max", a_cnt(1), 32'hFFFF_FFFF);
    rdchk("R7 no ovf yet", a_ctrl(1), 32'h027);
    ticks(1);
    rdchk("R7 wrapped", a_cnt(1), 0);
    rdchk("R7 ovf set", a_ctrl(1), 32'h4027);
    ticks(6);
    rdchk("R6 keeps counting", a_cnt(1), 6);
    rdchk("R6 match flag", a_ctrl(1), 32'hC027);
    chk("R9 irq ch1", 32'(irq_o), 2);
    wr(a_ctrl(1), 32'h8027);
    rdchk("R8 ovf cleared", a_ctrl(1), 32'h8027);
    wr(8'h00, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_map();
    t_periodic();
    t_clear();
    t_stop();
    t_prescale();
    t_load();
    t_overflow();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule